// File: doc/BRIEF.md
# Domain and Page Permission Gate

This block decides, one request at a time, whether a memory access that has already been translated may proceed. The request carries the domain number taken from the top-level descriptor that covers the address, the access-permission pairs from the mapping entry, the kind of mapping, a few address bits, whether the access is a write and whether it comes from user mode. A 32-bit control word holds a 2-bit policy for each of the 16 domains. That policy makes the domain deny everything, defer to the permission bits, or allow everything without looking at them.

Mappings with small or large pages can carry a different permission pair for each quarter of the page. The gate picks the right pair from the address bits before it applies the permission rule. The verdict is registered. Exactly one of allow, domain fault or permission fault is raised, one cycle after the request.

Top module: `perm_gate`

## Requirements
- R1: After reset the control word reads as zero, and `rsp_valid`, `rsp_allow`, `rsp_dom_fault` and `rsp_perm_fault` are all low.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored and appears on `cfg_rdata` from that edge on. A request presented in the same cycle as a write is judged with the old word. Without `cfg_we`, the word holds its value.
- R3: The policy of domain d is control bits [2d+1:2d]. A policy of 00 or 10 gives a domain fault and no allow, whatever the permission bits say.
- R4: A policy of 11 allows the access regardless of the permission bits, the mode and the direction.
- R5: A policy of 01 defers to the selected permission pair: allow if that pair permits the access, otherwise a permission fault.
- R6: Permission pair encoding: 00 denies everything; 01 allows supervisor read and write and denies all user access; 10 allows supervisor read and write and user read only; 11 allows read and write for both modes.
- R7: Quarter q uses `req_ap` bits [2q+1:2q]. For kind 01 (4 KB page), q is `req_vaddr[11:10]`. For kind 10 (64 KB page), q is `req_vaddr[15:14]`. For kind 00 (section) and kind 11 (1 KB page), q is 0.
- R8: When a response is valid, exactly one of allow, domain fault and permission fault is high. A domain fault always suppresses the permission fault.
- R9: The verdict for a request with `req_valid` high appears with `rsp_valid` high one cycle later. A cycle without a request gives a response with all four outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the domain control word |
| cfg_wdata | input | 32 | New domain control word |
| cfg_rdata | output | 32 | Current domain control word |
| req_valid | input | 1 | Request present this cycle |
| req_domain | input | 4 | Domain number of the access |
| req_kind | input | 2 | Mapping kind: 00 section, 01 4 KB, 10 64 KB, 11 1 KB |
| req_vaddr | input | 16 | Low virtual address bits |
| req_ap | input | 8 | Four permission pairs, quarter q at [2q+1:2q] |
| req_write | input | 1 | 1 for write, 0 for read |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Access allowed |
| rsp_dom_fault | output | 1 | Denied by domain policy |
| rsp_perm_fault | output | 1 | Denied by permission pair |

## Verification
The bench first drives every domain with policy 00 and then with policy 11, which separates the domain decision from the permission decision. It then holds all domains at 01 and sweeps every permission pair against both modes and both directions. The quarter sweep gives each quarter a distinct pair and steps the address bits through all four quarters for all four mapping kinds, so that a wrong address slice or a wrong field index changes the verdict. A long mixed run with random control words, including writes in the same cycle as requests, checks the policy field position and the timing of a write against the old word.

// File: rtl/perm_gate_pkg.sv
package perm_gate_pkg;

    typedef enum logic [1:0] {
        DOM_BLOCK   = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        KIND_SECTION = 2'b00,
        KIND_SMALL   = 2'b01,
        KIND_LARGE   = 2'b10,
        KIND_TINY    = 2'b11
    } map_kind_e;

    typedef struct packed {
        logic valid;
        logic allow;
        logic dom_fault;
        logic perm_fault;
    } verdict_t;

endpackage

// File: rtl/pg_ctrl_word.sv
module pg_ctrl_word #(
    parameter int CTRL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] value
);
    logic [CTRL_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (we) word_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign value = word_q;

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (value == $past(wdata)));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(value));

endmodule

// File: rtl/pg_domain_sel.sv
module pg_domain_sel
    import perm_gate_pkg::*;
#(
    parameter int NUM_DOM = 16,
    parameter int POL_W   = 2,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int CTRL_W = NUM_DOM * POL_W
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [DOM_W-1:0]  dom,
    output dom_mode_e         mode
);
    logic [POL_W-1:0] policy [NUM_DOM];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_unpack
        assign policy[g] = ctrl[g*POL_W +: POL_W];
    end

    assign mode = dom_mode_e'(policy[dom]);

endmodule

// File: rtl/pg_quarter_sel.sv
module pg_quarter_sel
    import perm_gate_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int AP_W      = 2,
    parameter int QUARTERS  = 4,
    parameter int SMALL_LSB = 10,
    parameter int LARGE_LSB = 14,
    localparam int Q_W      = $clog2(QUARTERS),
    localparam int BUNDLE_W = QUARTERS * AP_W
) (
    input  map_kind_e           kind,
    input  logic [VA_W-1:0]     vaddr,
    input  logic [BUNDLE_W-1:0] ap_bundle,
    output logic [AP_W-1:0]     ap,
    output logic [Q_W-1:0]      quarter
);
    logic [AP_W-1:0] ap_field [QUARTERS];
    logic            va_unused;

    for (genvar q = 0; q < QUARTERS; q++) begin : g_fields
        assign ap_field[q] = ap_bundle[q*AP_W +: AP_W];
    end

    always_comb begin
        case (kind)
            KIND_SMALL: quarter = vaddr[SMALL_LSB +: Q_W];
            KIND_LARGE: quarter = vaddr[LARGE_LSB +: Q_W];
            default:    quarter = '0;
        endcase
    end

    assign ap        = ap_field[quarter];
    assign va_unused = ^vaddr;

endmodule

// File: rtl/pg_ap_judge.sv
module pg_ap_judge #(
    parameter int AP_W = 2
) (
    input  logic [AP_W-1:0] ap,
    input  logic            write,
    input  logic            user,
    output logic            ok
);
    always_comb begin
        case (ap)
            2'b00:   ok = 1'b0;
            2'b01:   ok = !user;
            2'b10:   ok = !user || !write;
            default: ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/perm_gate.sv
module perm_gate
    import perm_gate_pkg::*;
#(
    parameter int NUM_DOM   = 16,
    parameter int POL_W     = 2,
    parameter int AP_W      = 2,
    parameter int QUARTERS  = 4,
    parameter int VA_W      = 16,
    parameter int SMALL_LSB = 10,
    parameter int LARGE_LSB = 14,
    localparam int DOM_W    = $clog2(NUM_DOM),
    localparam int CTRL_W   = NUM_DOM * POL_W,
    localparam int Q_W      = $clog2(QUARTERS),
    localparam int BUNDLE_W = QUARTERS * AP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CTRL_W-1:0]   cfg_wdata,
    output logic [CTRL_W-1:0]   cfg_rdata,
    input  logic                req_valid,
    input  logic [DOM_W-1:0]    req_domain,
    input  logic [1:0]          req_kind,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [BUNDLE_W-1:0] req_ap,
    input  logic                req_write,
    input  logic                req_user,
    output logic                rsp_valid,
    output logic                rsp_allow,
    output logic                rsp_dom_fault,
    output logic                rsp_perm_fault
);
    logic [CTRL_W-1:0] ctrl;
    dom_mode_e         mode;
    logic [AP_W-1:0]   ap_sel;
    logic [Q_W-1:0]    quarter;
    logic              ap_ok;
    verdict_t          verdict_d, verdict_q;

    pg_ctrl_word #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .value (ctrl)
    );

    pg_domain_sel #(.NUM_DOM(NUM_DOM), .POL_W(POL_W)) u_dom (
        .ctrl (ctrl),
        .dom  (req_domain),
        .mode (mode)
    );

    pg_quarter_sel #(
        .VA_W(VA_W), .AP_W(AP_W), .QUARTERS(QUARTERS),
        .SMALL_LSB(SMALL_LSB), .LARGE_LSB(LARGE_LSB)
    ) u_qsel (
        .kind      (map_kind_e'(req_kind)),
        .vaddr     (req_vaddr),
        .ap_bundle (req_ap),
        .ap        (ap_sel),
        .quarter   (quarter)
    );

    pg_ap_judge #(.AP_W(AP_W)) u_judge (
        .ap    (ap_sel),
        .write (req_write),
        .user  (req_user),
        .ok    (ap_ok)
    );

    always_comb begin
        verdict_d = '0;
        if (req_valid) begin
            verdict_d.valid = 1'b1;
            case (mode)
                DOM_MANAGER: verdict_d.allow = 1'b1;
                DOM_CLIENT: begin
                    verdict_d.allow      = ap_ok;
                    verdict_d.perm_fault = !ap_ok;
                end
                default:     verdict_d.dom_fault = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) verdict_q <= '0;
        else        verdict_q <= verdict_d;
    end

    assign cfg_rdata      = ctrl;
    assign rsp_valid      = verdict_q.valid;
    assign rsp_allow      = verdict_q.allow;
    assign rsp_dom_fault  = verdict_q.dom_fault;
    assign rsp_perm_fault = verdict_q.perm_fault;

    // R8
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_allow, rsp_dom_fault, rsp_perm_fault}) == 1));

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_valid || rsp_allow || rsp_dom_fault || rsp_perm_fault));

    // R4
    manager_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == DOM_MANAGER) |=> rsp_allow);

    // R3
    blocked_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (mode == DOM_BLOCK || mode == DOM_RSVD)) |=> (rsp_dom_fault && !rsp_allow));

    // R5
    client_no_domfault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == DOM_CLIENT) |=> !rsp_dom_fault);

endmodule

// File: tb/perm_gate_bench.sv
module perm_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [3:0]  req_domain = '0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_vaddr = '0;
    logic [7:0]  req_ap = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault;

    int checks = 0;
    int failures = 0;

    logic [31:0] ctrl_ref = '0;
    logic        e_valid = 0, e_allow = 0, e_dfault = 0, e_pfault = 0;
    logic [31:0] e_rdata = '0;
    string       e_tag = "R1";

    always #2 clk = ~clk;

    perm_gate u_perm_gate (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_domain(req_domain), .req_kind(req_kind),
        .req_vaddr(req_vaddr), .req_ap(req_ap), .req_write(req_write),
        .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_dom_fault(rsp_dom_fault), .rsp_perm_fault(rsp_perm_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference built from the requirement text
    task automatic judge(input logic [31:0] word, input int dom, input int kind,
                         input int va, input int ap, input bit wr, input bit usr,
                         output bit a, output bit df, output bit pf);
        int pol, q, pair;
        bit ok;
        pol = (word >> (dom * 2)) & 3;                 // R3 policy position
        if (kind == 1)      q = (va >> 10) & 3;        // R7
        else if (kind == 2) q = (va >> 14) & 3;
        else                q = 0;
        pair = (ap >> (q * 2)) & 3;
        case (pair)                                    // R6
            0: ok = 0;
            1: ok = !usr;
            2: ok = !usr || !wr;
            default: ok = 1;
        endcase
        a = 0; df = 0; pf = 0;
        if (pol == 3)      a = 1;                      // R4
        else if (pol == 1) begin a = ok; pf = !ok; end // R5
        else               df = 1;                     // R3
    endtask

    task automatic step(input string tag, input bit we, input logic [31:0] wd,
                        input bit v, input int dom, input int kind, input int va,
                        input int ap, input bit wr, input bit usr);
        bit a, df, pf;
        @(negedge clk);
        check({e_tag, " R9 valid"}, {31'd0, rsp_valid}, {31'd0, e_valid});
        check({e_tag, " allow"},    {31'd0, rsp_allow}, {31'd0, e_allow});
        check({e_tag, " R3 dom"},   {31'd0, rsp_dom_fault}, {31'd0, e_dfault});
        check({e_tag, " R5 perm"},  {31'd0, rsp_perm_fault}, {31'd0, e_pfault});
        check("R2 rdata", cfg_rdata, e_rdata);
        check("R8 exclusive", {31'd0, (rsp_dom_fault && rsp_perm_fault)}, 32'd0);
        cfg_we = we; cfg_wdata = wd; req_valid = v;
        req_domain = dom[3:0]; req_kind = kind[1:0]; req_vaddr = va[15:0];
        req_ap = ap[7:0]; req_write = wr; req_user = usr;
        judge(ctrl_ref, dom, kind, va, ap, wr, usr, a, df, pf);
        e_valid = v; e_allow = v && a; e_dfault = v && df; e_pfault = v && pf;
        e_tag = tag;
        if (we) ctrl_ref = wd;
        e_rdata = ctrl_ref;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", cfg_rdata, 32'd0);
        check("R1 outs", {28'd0, rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault}, 32'd0);
        rst_n = 1'b1;

        // R3: every domain blocked after reset
        for (int d = 0; d < 16; d++) step("R3", 0, 0, 1, d, d % 4, d * 997, 8'hFF, d[0], d[1]);
        // R3: reserved policy 10 everywhere
        step("R2", 1, 32'hAAAA_AAAA, 1, 5, 0, 0, 8'hFF, 0, 0);
        for (int d = 0; d < 16; d++) step("R3", 0, 0, 1, d, 0, 0, 8'hFF, 0, 0);

        // R4: manager everywhere, permissions that would deny
        step("R2", 1, 32'hFFFF_FFFF, 1, 2, 0, 0, 0, 1, 1);
        for (int d = 0; d < 16; d++) step("R4", 0, 0, 1, d, d % 4, d * 4099, 0, 1, 1);

        // R6: client everywhere, every pair against mode and direction
        step("R2", 1, 32'h5555_5555, 0, 0, 0, 0, 0, 0, 0);
        for (int ap = 0; ap < 4; ap++)
            for (int m = 0; m < 4; m++)
                step("R6", 0, 0, 1, ap * 3, 0, 0, ap, m[0], m[1]);

        // R7: distinct pair per quarter, all kinds and quarters
        for (int k = 0; k < 4; k++)
            for (int q = 0; q < 4; q++) begin
                step("R7", 0, 0, 1, 7, k, (q << 10) | ((3 - q) << 14), 8'b11_10_01_00, 0, 1);
                step("R7", 0, 0, 1, 7, k, (q << 14) | ((3 - q) << 10), 8'b00_01_10_11, 1, 1);
            end

        // R9: idle cycles produce quiet outputs
        for (int i = 0; i < 4; i++) step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R5 and R2: mixed random run with writes alongside requests
        for (int i = 0; i < 400; i++) begin
            bit we;
            we = ($urandom % 8) == 0;
            step("R5", we, $urandom, ($urandom % 5) != 0, $urandom % 16, $urandom % 4,
                 $urandom % 65536, $urandom % 256, $urandom % 2, $urandom % 2);
        end
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule